// File: doc/BRIEF.md
# Four-Operand Byte Averaging Unit

This unit carries out the two-dimensional half-pixel interpolation step of motion-compensated video decoding. It takes four 64-bit vector operands, each packed with eight unsigned byte pixels. In every byte lane it adds the four co-located pixels at a width wide enough to keep every carry, adds a rounding constant, and divides by four. The eight results are packed back into a single 64-bit result word. Each result byte sits in the same lane position as its source bytes.

The unit is a double-slot super-operation, which is why it accepts four operands instead of the usual two. It is fully pipelined and has a fixed latency of two cycles. An operation can be issued every cycle, and there is no stall path. Each issued operation brings a destination tag, which is returned unchanged with its result. It also brings a guard bit. When the guard is false the operation still flows through the pipeline, but it emerges with its write enable held low.

Operation tracking uses one small state register per pipeline stage. The states are:
- `SLOT_EMPTY`: no operation in the stage.
- `SLOT_LIVE`: a guarded-true operation in the stage.
- `SLOT_SQUASHED`: a guarded-false operation in the stage.

The transitions are:
- **fill-live**: an issue with the guard set moves the first stage to `SLOT_LIVE`.
- **fill-squashed**: an issue with the guard clear moves the first stage to `SLOT_SQUASHED`.
- **drain**: with no issue, the first stage returns to `SLOT_EMPTY`.
- **advance**: every later stage copies the state of the stage before it.
- **flush**: reset forces every stage to `SLOT_EMPTY`.

Top module: `quad_avg_unit`

## Requirements
- R1: For each lane i (bits 8i+7:8i, lane 0 = bits 7:0), the result byte equals (a+b+c+d+2)>>2 of the four operand bytes in lane i. The result lane order equals the operand lane order.
- R2: No carry is lost. Four bytes of 0xFF give 0xFF, and every other input combination also gives a result that fits in 8 bits.
- R3: Rounding is to nearest with ties upward. A lane sum whose remainder mod 4 is 0 or 1 rounds down. A lane sum whose remainder is 2 or 3 rounds up.
- R4: An operation sampled with `in_valid` high at clock edge k appears with `out_valid` high after edge k+1, together with its own `in_tag` on `out_tag`. With no issue, no `out_valid` appears two edges later.
- R5: `out_wen` equals the issued guard bit for the operation on the output. A false guard still produces `out_valid` high, with `out_wen` low. `out_wen` is never high without `out_valid`.
- R6: While `rst_n` is low, `out_valid` and `out_wen` are low. Asserting `rst_n` low discards any operation in flight.
- R7: Operations issued on consecutive cycles complete on consecutive cycles, in issue order, with no stall or bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is issued this cycle |
| in_guard | input | 1 | Guard bit; low suppresses the result write |
| in_tag | input | 7 | Destination register tag |
| src_a | input | 64 | First operand, eight unsigned bytes |
| src_b | input | 64 | Second operand |
| src_c | input | 64 | Third operand |
| src_d | input | 64 | Fourth operand |
| out_valid | output | 1 | A result is on the output this cycle |
| out_wen | output | 1 | Result write enable (valid and guard true) |
| out_tag | output | 7 | Tag of the result on the output |
| out_data | output | 64 | Eight averaged bytes |

## Verification
The checker assumes that the operands, guard and tag are stable and known at every edge where `in_valid` is high. It also assumes that reset is not released in the same cycle that an operation is issued. The bench meets both assumptions by changing every input only on the falling clock edge. It keeps `in_valid` low throughout reset and on the first edge after release, and it keeps tags within seven bits. Operand patterns come from a fixed table plus directed cases, including saturated bytes and every remainder of the lane sum, so all four rounding cases are reached.

// File: rtl/qavg_pkg.sv
package qavg_pkg;

    localparam int unsigned QAVG_LANES  = 8;
    localparam int unsigned QAVG_LANE_W = 8;
    localparam int unsigned QAVG_TAG_W  = 7;
    localparam int unsigned QAVG_STAGES = 2;

    // Occupancy of one pipeline stage
    typedef enum logic [1:0] {
        SLOT_EMPTY    = 2'b00,
        SLOT_LIVE     = 2'b01,
        SLOT_SQUASHED = 2'b10
    } slot_state_e;

endpackage

// File: rtl/qavg_pair_add.sv
module qavg_pair_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   s
);
    // Pairwise sum with one guard bit so the carry is kept
    always_comb begin
        s = {1'b0, x} + {1'b0, y};
    end
endmodule

// File: rtl/qavg_lane_final.sv
module qavg_lane_final #(
    parameter int unsigned W = 8
) (
    input  logic [W:0]   p,
    input  logic [W:0]   q,
    output logic [W-1:0] avg
);
    localparam int unsigned TW = W + 2;

    logic [TW-1:0] total;

    // Final level of the tree: both pair sums plus the rounding constant 2
    always_comb begin
        total = {1'b0, p} + {1'b0, q} + TW'(2);
        avg   = total[TW-1:2];
    end
endmodule

// File: rtl/qavg_ctrl_pipe.sv
module qavg_ctrl_pipe
    import qavg_pkg::*;
#(
    parameter int unsigned TAG_W  = QAVG_TAG_W,
    parameter int unsigned STAGES = QAVG_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_guard,
    input  logic [TAG_W-1:0] in_tag,
    output logic             first_busy,
    output logic             out_valid,
    output logic             out_wen,
    output logic [TAG_W-1:0] out_tag
);
    slot_state_e      st [STAGES];
    logic [TAG_W-1:0] tg [STAGES];
    slot_state_e      entry_st;

    // Next state of the first stage: fill-live, fill-squashed or drain
    always_comb begin
        unique case ({in_valid, in_guard})
            2'b11:   entry_st = SLOT_LIVE;
            2'b10:   entry_st = SLOT_SQUASHED;
            default: entry_st = SLOT_EMPTY;
        endcase
    end

    // State registers: flush on reset, advance otherwise
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st[s] <= SLOT_EMPTY;
                    tg[s] <= '0;
                end else begin
                    st[s] <= entry_st;
                    tg[s] <= in_tag;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st[s] <= SLOT_EMPTY;
                    tg[s] <= '0;
                end else begin
                    st[s] <= st[s-1];
                    tg[s] <= tg[s-1];
                end
            end
        end
    end

    // Output decode from the last stage
    always_comb begin
        first_busy = (st[0] != SLOT_EMPTY);
        out_tag    = tg[STAGES-1];
        unique case (st[STAGES-1])
            SLOT_LIVE: begin
                out_valid = 1'b1;
                out_wen   = 1'b1;
            end
            SLOT_SQUASHED: begin
                out_valid = 1'b1;
                out_wen   = 1'b0;
            end
            default: begin
                out_valid = 1'b0;
                out_wen   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/quad_avg_unit.sv
module quad_avg_unit
    import qavg_pkg::*;
#(
    parameter int unsigned LANES  = QAVG_LANES,
    parameter int unsigned LANE_W = QAVG_LANE_W,
    parameter int unsigned TAG_W  = QAVG_TAG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_guard,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANES*LANE_W-1:0] src_c,
    input  logic [LANES*LANE_W-1:0] src_d,
    output logic                    out_valid,
    output logic                    out_wen,
    output logic [TAG_W-1:0]        out_tag,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int unsigned PAIR_W = LANE_W + 1;

    logic first_busy;

    qavg_ctrl_pipe #(
        .TAG_W  (TAG_W),
        .STAGES (QAVG_STAGES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_guard   (in_guard),
        .in_tag     (in_tag),
        .first_busy (first_busy),
        .out_valid  (out_valid),
        .out_wen    (out_wen),
        .out_tag    (out_tag)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PAIR_W-1:0] ab_c, cd_c;
        logic [PAIR_W-1:0] ab_q, cd_q;
        logic [LANE_W-1:0] avg_c, avg_q;

        qavg_pair_add #(.W(LANE_W)) u_ab (
            .x (src_a[l*LANE_W +: LANE_W]),
            .y (src_b[l*LANE_W +: LANE_W]),
            .s (ab_c)
        );

        qavg_pair_add #(.W(LANE_W)) u_cd (
            .x (src_c[l*LANE_W +: LANE_W]),
            .y (src_d[l*LANE_W +: LANE_W]),
            .s (cd_c)
        );

        // Stage 1: pairwise sums, loaded only on issue
        always_ff @(posedge clk) begin
            if (in_valid) begin
                ab_q <= ab_c;
                cd_q <= cd_c;
            end
        end

        qavg_lane_final #(.W(LANE_W)) u_fin (
            .p   (ab_q),
            .q   (cd_q),
            .avg (avg_c)
        );

        // Stage 2: rounded average, loaded when stage 1 holds an operation
        always_ff @(posedge clk) begin
            if (first_busy) begin
                avg_q <= avg_c;
            end
        end

        assign out_data[l*LANE_W +: LANE_W] = avg_q;
    end
endmodule

// File: rtl/qavg_checker.sv
module qavg_checker #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned TAG_W  = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_guard,
    input logic [TAG_W-1:0]        in_tag,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANES*LANE_W-1:0] src_b,
    input logic [LANES*LANE_W-1:0] src_c,
    input logic [LANES*LANE_W-1:0] src_d,
    input logic                    out_valid,
    input logic                    out_wen,
    input logic [TAG_W-1:0]        out_tag,
    input logic [LANES*LANE_W-1:0] out_data
);
    localparam int unsigned VW = LANES * LANE_W;

    logic [VW-1:0] ref_c;

    // Reference average: one wide sum per lane, then divide by four
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            int unsigned sum;
            sum = int'(src_a[l*LANE_W +: LANE_W]) + int'(src_b[l*LANE_W +: LANE_W])
                + int'(src_c[l*LANE_W +: LANE_W]) + int'(src_d[l*LANE_W +: LANE_W]) + 2;
            ref_c[l*LANE_W +: LANE_W] = LANE_W'(sum / 4);
        end
    end

    a_r1_lane_avg: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_data == $past(ref_c, 2)));

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r4_tag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_tag == $past(in_tag, 2)));

    a_r5_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_guard) |-> ##2 (out_valid && !out_wen));

    a_r5_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_guard) |-> ##2 out_wen);

    a_r5_wen_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_valid);

    a_r6_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_wen));
endmodule

bind quad_avg_unit qavg_checker #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .TAG_W  (TAG_W)
) u_qavg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_guard  (in_guard),
    .in_tag    (in_tag),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_c     (src_c),
    .src_d     (src_d),
    .out_valid (out_valid),
    .out_wen   (out_wen),
    .out_tag   (out_tag),
    .out_data  (out_data)
);

// File: tb/quad_avg_unit_tb.sv
module quad_avg_unit_tb_top;

    localparam int unsigned NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_guard = 1'b0;
    logic [6:0]  in_tag = '0;
    logic [63:0] src_a = '0, src_b = '0, src_c = '0, src_d = '0;
    logic        out_valid, out_wen;
    logic [6:0]  out_tag;
    logic [63:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    quad_avg_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_guard  (in_guard),
        .in_tag    (in_tag),
        .src_a     (src_a),
        .src_b     (src_b),
        .src_c     (src_c),
        .src_d     (src_d),
        .out_valid (out_valid),
        .out_wen   (out_wen),
        .out_tag   (out_tag),
        .out_data  (out_data)
    );

    // Stimulus table: four operands per row
    localparam logic [63:0] TV_A [NV] = '{
        64'h0302010003020100, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 64'h80FF00FF7F010203,
        64'hFFFEFDFC00010203, 64'h1111111111111111, 64'hA5A5A5A55A5A5A5A, 64'h0000000000000000 };
    localparam logic [63:0] TV_B [NV] = '{
        64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'hFEDCBA9876543210, 64'h80FF00FF7F010203,
        64'hFFFFFFFF01010101, 64'h2222222222222222, 64'h5A5A5A5AA5A5A5A5, 64'h0000000000000001 };
    localparam logic [63:0] TV_C [NV] = '{
        64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0F1E2D3C4B5A6978, 64'h7F00FF0080FEFDFC,
        64'hFFFFFFFF02020202, 64'h3333333333333333, 64'hFF00FF0000FF00FF, 64'h0000000000000100 };
    localparam logic [63:0] TV_D [NV] = '{
        64'h0000000000000000, 64'hFFFFFFFFFFFFFFFE, 64'h8796A5B4C3D2E1F0, 64'h7F00FF0080FEFDFC,
        64'hFFFFFFFF03030303, 64'h4444444444444444, 64'h00FF00FFFF00FF00, 64'h0000000000010000 };

    // Model from R1: per lane (a+b+c+d+2)>>2, lane l at bits 8l+7:8l
    function automatic logic [63:0] model(input logic [63:0] a, b, c, d);
        logic [63:0] r;
        for (int l = 0; l < 8; l++) begin
            int unsigned s;
            s = int'(a[l*8 +: 8]) + int'(b[l*8 +: 8]) + int'(c[l*8 +: 8]) + int'(d[l*8 +: 8]) + 2;
            r[l*8 +: 8] = 8'(s >> 2);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic g, input logic [6:0] t,
                         input logic [63:0] a, b, c, d);
        in_valid = v; in_guard = g; in_tag = t;
        src_a = a; src_b = b; src_c = c; src_d = d;
    endtask

    // Issue one operation, then idle, and check it two falling edges later
    task automatic single(input string req, input logic g, input logic [6:0] t,
                          input logic [63:0] a, b, c, d, input logic [63:0] exp);
        @(negedge clk);
        drive(1'b1, g, t, a, b, c, d);
        @(negedge clk);
        drive(1'b0, 1'b0, 7'd0, 64'd0, 64'd0, 64'd0, 64'd0);
        @(negedge clk);
        chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
        chk({req, " wen"}, {63'd0, out_wen}, {63'd0, g});
        chk({req, " tag"}, {57'd0, out_tag}, {57'd0, t});
        chk({req, " data"}, out_data, exp);
    endtask

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk("R6 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R6 reset wen", {63'd0, out_wen}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 / R1 / R5: back-to-back issue of the table, guard false every third op
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int k;
                k = i - 2;
                chk("R7 stream valid", {63'd0, out_valid}, 64'd1);
                chk("R5 stream wen", {63'd0, out_wen}, {63'd0, (k % 3) != 2});
                chk("R4 stream tag", {57'd0, out_tag}, 64'(k));
                chk("R1 stream data", out_data, model(TV_A[k], TV_B[k], TV_C[k], TV_D[k]));
            end
            if (i < NV)
                drive(1'b1, (i % 3) != 2, 7'(i), TV_A[i], TV_B[i], TV_C[i], TV_D[i]);
            else
                drive(1'b0, 1'b0, 7'd0, 64'd0, 64'd0, 64'd0, 64'd0);
        end
        @(negedge clk);
        chk("R4 idle no valid", {63'd0, out_valid}, 64'd0);

        // R3 and lane order: lane sums 0,1,2,3 round to 0,0,1,1
        single("R3 round", 1'b1, 7'h11, 64'h0302010003020100, 64'd0, 64'd0, 64'd0,
               64'h0101000001010000);
        // R3: sums 4..7 round to 1,1,2,2
        single("R3 round high", 1'b1, 7'h12, 64'h0706050407060504, 64'd0, 64'd0, 64'd0,
               64'h0202010102020101);
        // R2: saturated bytes keep all carries
        single("R2 max", 1'b1, 7'h7F, '1, '1, '1, '1, 64'hFFFFFFFFFFFFFFFF);
        single("R2 near max", 1'b1, 7'h00, '1, '1, '1, 64'hFEFEFEFEFEFEFEFE,
               64'hFFFFFFFFFFFFFFFF);
        // R1: lane order, distinct value only in lane 7 and lane 0
        single("R1 lanes", 1'b1, 7'h05, 64'h4000000000000008, 64'h4000000000000008,
               64'h4000000000000008, 64'h4000000000000008, 64'h4000000000000008);
        // R5: guard false still returns valid and tag, write suppressed
        single("R5 squash", 1'b0, 7'h2A, 64'h0404040404040404, 64'd0, 64'd0, 64'd0,
               64'h0101010101010101);

        // R6: reset in flight discards the operation
        @(negedge clk);
        drive(1'b1, 1'b1, 7'h33, '1, '1, '1, '1);
        @(negedge clk);
        drive(1'b0, 1'b0, 7'd0, 64'd0, 64'd0, 64'd0, 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 flush valid", {63'd0, out_valid}, 64'd0);
        chk("R6 flush wen", {63'd0, out_wen}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 after flush idle", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule